// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that works through a chain of descriptors kept in memory. Software points the channel at the first descriptor, turns the channel on and writes the doorbell. The channel then loads one descriptor at a time. Each descriptor is eight words on a 32-byte boundary. A descriptor marked valid is carried out: the channel copies the requested data, writes a status word if the descriptor asks for one, clears the descriptor's valid flag if asked, and records a completion. It then moves on to the descriptor that the next pointer names. The walk stops on the first descriptor whose valid flag is clear. The channel leaves its pointer on that descriptor, so software can fill it in and write the doorbell again.

The channel has two ports. The register port is a single-cycle write strobe with a combinational read. The memory port is word-wide, with a valid/ready request and a response strobe for reads. Descriptor loads, data reads, data writes and status writes all share that one memory port.

Top module: `dma_chain_channel`

## Requirements
- R1: After reset the status register reads 1 (halted only). The irq register, the byte-count register and the descriptor pointer read 0, `done_irq` is low and no memory request is raised.
- R2: Register word offsets on `reg_addr` are: 0 config (bit 0 enable), 1 descriptor pointer, 2 status pointer, 3 doorbell, 4 irq, 5 status, 6 byte count. A doorbell write of any value starts the walk at the descriptor pointer when enable is 1. When enable is 0 it causes no memory request and no status change. The descriptor pointer drops its low 5 bits and accepts writes only while the channel is halted. The status pointer drops its low 2 bits.
- R3: The channel reads the descriptor words at offsets 0x00 through 0x1C in ascending order. Word 0 is the command, word 1 the count word, word 2 the source address, word 4 the destination address, word 6 the status slot and word 7 the next pointer. If word 0 bit 31 is 0, the channel halts after that single read and keeps its pointer on the descriptor, so the next doorbell reads it again.
- R4: The copy moves floor(count/4) words, where count is word 1 bits [21:0]. The source address rises by 4 after each word. The destination rises by 4 when word 0 bit 30 is 1 and stays fixed when it is 0. A count below 4 moves nothing.
- R5: After the copy, word 0 bits [1:0] choose one status write: 0 none, 1 the status register value (0x6 while running), 2 word 0 with bit 31 cleared, 3 the residue count mod 4. The write goes to descriptor+0x18 when word 0 bit 4 is 0 and to the status pointer when it is 1.
- R6: When word 0 bit 2 is 1, the channel then writes word 0 with bit 31 cleared back to descriptor+0x00.
- R7: After a completion, the next descriptor address is word 7 bits [26:0] shifted left by 5. Bits [31:27] are ignored.
- R8: Every completion sets irq bit 0. `done_irq` is high while some descriptor completed since the last clear had word 0 bit 8 set. Writing 1 to irq bit 0 clears both. A completion in the same cycle as the clear wins.
- R9: Status bit 0 means halted, bit 1 means a valid descriptor is being processed, and bit 2 means the doorbell was pushed. Bits 1 and 2 clear when the channel halts. The byte-count register reads the last residue (count mod 4) while halted and 0 while running.
- R10: Memory requests are word-aligned. A request holds its address and direction steady until ready. At most one read is outstanding, and no new request is made while a read response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_rdata | input | 32 | Read response data |
| done_irq | output | 1 | Interrupt for enabled completions |

## Verification
The two functions that can meet in one cycle are the completion of a descriptor and a software clear of the irq bit. The bench holds memory ready high and runs a descriptor that only clears its own valid flag. It watches the port for the accepted clear-valid write, then issues the irq clear on the following cycle, which is the completion cycle. The irq bit must still read 1 afterwards, and a clear made at any other time must bring it to 0.

// File: rtl/dmac_pkg.sv
// Shared constants and state encoding for the linked-descriptor DMA channel.
// Assumes 32-bit registers and descriptor words.
package dmac_pkg;
    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] RA_CFG   = 3'd0;
    localparam logic [REG_AW-1:0] RA_DPTR  = 3'd1;
    localparam logic [REG_AW-1:0] RA_SPTR  = 3'd2;
    localparam logic [REG_AW-1:0] RA_DBELL = 3'd3;
    localparam logic [REG_AW-1:0] RA_IRQ   = 3'd4;
    localparam logic [REG_AW-1:0] RA_STAT  = 3'd5;
    localparam logic [REG_AW-1:0] RA_BCNT  = 3'd6;

    // command word bit positions
    localparam int C0_VALID = 31;
    localparam int C0_MEM   = 30;
    localparam int C0_IE    = 8;
    localparam int C0_SPSEL = 4;
    localparam int C0_CLRV  = 2;

    // descriptor word indices
    localparam int DW_CMD  = 0;
    localparam int DW_CNT  = 1;
    localparam int DW_SRC  = 2;
    localparam int DW_DST  = 4;
    localparam int DW_STAT = 6;
    localparam int DW_NEXT = 7;

    typedef enum logic [3:0] {
        ST_IDLE,   // halted, waiting for a doorbell
        ST_FETCH,  // request one descriptor word
        ST_FWAIT,  // wait for that word
        ST_LOAD,   // latch copy pointers and count
        ST_CHK,    // decide next step of the copy
        ST_CRD,    // request source word
        ST_CRW,    // wait for source word
        ST_CWR,    // write destination word
        ST_STW,    // status write-back
        ST_CVW,    // clear-valid write-back
        ST_DONE    // completion, follow next pointer
    } eng_state_e;
endpackage

// File: rtl/dmac_regs.sv
// Register file of the DMA channel: config, status pointer and irq state,
// doorbell qualification and the combinational read mux.
// Assumes at most one register write per cycle; reads have no side effects.
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int CNT_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              cfg_en,
    output logic [31:0]       stat_ptr,
    output logic              go,
    output logic              dptr_we,
    output logic [31:0]       dptr_wdata,
    output logic              irq_flag,
    output logic              irq_out,
    input  logic [31:0]       dptr,
    input  logic              halted,
    input  logic              dvalid,
    input  logic              dbell,
    input  logic [CNT_W-1:0]  rem,
    input  logic              cmp,
    input  logic              cmp_ie
);
    logic wr_cfg, wr_sptr, wr_irq;
    logic ie_seen_q;

    assign wr_cfg     = reg_we && (reg_addr == RA_CFG);
    assign wr_sptr    = reg_we && (reg_addr == RA_SPTR);
    assign wr_irq     = reg_we && (reg_addr == RA_IRQ) && reg_wdata[0];
    assign go         = reg_we && (reg_addr == RA_DBELL) && cfg_en;
    assign dptr_we    = reg_we && (reg_addr == RA_DPTR);
    assign dptr_wdata = reg_wdata;
    assign irq_out    = ie_seen_q;

    // config enable and status pointer storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_en   <= 1'b0;
            stat_ptr <= '0;
        end else begin
            if (wr_cfg)  cfg_en   <= reg_wdata[0];
            if (wr_sptr) stat_ptr <= {reg_wdata[31:2], 2'b00};
        end
    end

    // completion flag and interrupt-enable memory; completion beats clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_flag  <= 1'b0;
            ie_seen_q <= 1'b0;
        end else if (cmp) begin
            irq_flag <= 1'b1;
            if (cmp_ie) ie_seen_q <= 1'b1;
        end else if (wr_irq) begin
            irq_flag  <= 1'b0;
            ie_seen_q <= 1'b0;
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_CFG:  reg_rdata = {31'd0, cfg_en};
            RA_DPTR: reg_rdata = dptr;
            RA_SPTR: reg_rdata = stat_ptr;
            RA_IRQ:  reg_rdata = {31'd0, irq_flag};
            RA_STAT: reg_rdata = {29'd0, dbell, dvalid, halted};
            RA_BCNT: reg_rdata = halted ? {{(32-CNT_W){1'b0}}, rem} : 32'd0;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dmac_engine.sv
// Descriptor walker: loads a descriptor, copies data word by word, performs
// the optional status and clear-valid writes, then chains to the next one.
// Assumes the memory port keeps request/response ordering and that writes
// complete at the request handshake.
module dmac_engine
    import dmac_pkg::*;
#(
    parameter int CNT_W      = 22,
    parameter int DESC_WORDS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             dptr_we,
    input  logic [31:0]      dptr_wdata,
    input  logic [31:0]      stat_ptr,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic             mem_req_write,
    output logic [31:0]      mem_req_addr,
    output logic [31:0]      mem_req_wdata,
    input  logic             mem_rsp_valid,
    input  logic [31:0]      mem_rsp_rdata,
    output logic [31:0]      dptr,
    output logic             halted,
    output logic             dvalid,
    output logic             dbell,
    output logic [CNT_W-1:0] rem,
    output logic             cmp,
    output logic             cmp_ie
);
    localparam int IDX_W   = $clog2(DESC_WORDS);
    localparam int ALIGN_B = $clog2(DESC_WORDS * 4);

    eng_state_e         state_q;
    logic [IDX_W-1:0]   idx_q;
    logic [31:0]        word_q [DESC_WORDS];
    logic [31:0]        src_q, dst_q, buf_q;
    logic               hs;
    logic [31:0]        cmd0;
    logic [1:0]         st_sel;
    logic [31:0]        st_addr, st_data;

    assign hs     = mem_req_valid && mem_req_ready;
    assign cmd0   = word_q[DW_CMD];
    assign st_sel = cmd0[1:0];
    assign cmp    = (state_q == ST_DONE);
    assign cmp_ie = cmd0[C0_IE];

    // capture each descriptor word as its response arrives
    for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q[g] <= '0;
            else if (state_q == ST_FWAIT && mem_rsp_valid && idx_q == IDX_W'(g))
                word_q[g] <= mem_rsp_rdata;
        end
    end

    // status write target and value
    always_comb begin
        st_addr = cmd0[C0_SPSEL] ? stat_ptr : (dptr + 32'(DW_STAT * 4));
        unique case (st_sel)
            2'd1:    st_data = {29'd0, dbell, dvalid, halted};
            2'd2:    st_data = {1'b0, cmd0[30:0]};
            2'd3:    st_data = {{(32-CNT_W){1'b0}}, rem};
            default: st_data = '0;
        endcase
    end

    // memory request driven from the current state
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = '0;
        unique case (state_q)
            ST_FETCH: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = dptr + {{(30-IDX_W){1'b0}}, idx_q, 2'b00};
            end
            ST_CRD: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = src_q;
            end
            ST_CWR: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = dst_q;
                mem_req_wdata = buf_q;
            end
            ST_STW: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = st_addr;
                mem_req_wdata = st_data;
            end
            ST_CVW: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = dptr;
                mem_req_wdata = {1'b0, cmd0[30:0]};
            end
            default: ;
        endcase
    end

    // channel sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            dptr    <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            buf_q   <= '0;
            rem     <= '0;
            halted  <= 1'b1;
            dvalid  <= 1'b0;
            dbell   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (dptr_we)
                        dptr <= {dptr_wdata[31:ALIGN_B], {ALIGN_B{1'b0}}};
                    if (go) begin
                        state_q <= ST_FETCH;
                        idx_q   <= '0;
                        halted  <= 1'b0;
                    end
                end
                ST_FETCH: if (hs) state_q <= ST_FWAIT;
                ST_FWAIT: begin
                    if (mem_rsp_valid) begin
                        if (idx_q == '0 && !mem_rsp_rdata[C0_VALID]) begin
                            state_q <= ST_IDLE;
                            halted  <= 1'b1;
                            dvalid  <= 1'b0;
                            dbell   <= 1'b0;
                        end else begin
                            if (idx_q == '0) dvalid <= 1'b1;
                            if (idx_q == IDX_W'(DESC_WORDS - 1)) begin
                                state_q <= ST_LOAD;
                            end else begin
                                idx_q   <= idx_q + 1'b1;
                                state_q <= ST_FETCH;
                            end
                        end
                    end
                end
                ST_LOAD: begin
                    src_q   <= word_q[DW_SRC];
                    dst_q   <= word_q[DW_DST];
                    rem     <= word_q[DW_CNT][CNT_W-1:0];
                    state_q <= ST_CHK;
                end
                ST_CHK: begin
                    if (rem >= CNT_W'(4))        state_q <= ST_CRD;
                    else if (st_sel != 2'd0)     state_q <= ST_STW;
                    else if (cmd0[C0_CLRV])      state_q <= ST_CVW;
                    else                         state_q <= ST_DONE;
                end
                ST_CRD: if (hs) state_q <= ST_CRW;
                ST_CRW: begin
                    if (mem_rsp_valid) begin
                        buf_q   <= mem_rsp_rdata;
                        state_q <= ST_CWR;
                    end
                end
                ST_CWR: begin
                    if (hs) begin
                        src_q   <= src_q + 32'd4;
                        if (cmd0[C0_MEM]) dst_q <= dst_q + 32'd4;
                        rem     <= rem - CNT_W'(4);
                        state_q <= ST_CHK;
                    end
                end
                ST_STW: if (hs) state_q <= cmd0[C0_CLRV] ? ST_CVW : ST_DONE;
                ST_CVW: if (hs) state_q <= ST_DONE;
                ST_DONE: begin
                    dptr    <= {word_q[DW_NEXT][31-ALIGN_B:0], {ALIGN_B{1'b0}}};
                    idx_q   <= '0;
                    dvalid  <= 1'b0;
                    state_q <= ST_FETCH;
                end
                default: state_q <= ST_IDLE;
            endcase
            if (go) dbell <= 1'b1;
        end
    end
endmodule

// File: rtl/dma_chain_channel.sv
// Top of the linked-descriptor DMA channel: joins the register file and
// the descriptor engine. Assumes a single memory port shared by all accesses.
module dma_chain_channel
    import dmac_pkg::*;
#(
    parameter int CNT_W      = 22,
    parameter int DESC_WORDS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic        mem_req_write,
    output logic [31:0] mem_req_addr,
    output logic [31:0] mem_req_wdata,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_rdata,
    output logic        done_irq
);
    logic             cfg_en, go, dptr_we, irq_flag;
    logic [31:0]      stat_ptr, dptr_wdata, dptr;
    logic             halted, dvalid, dbell, cmp, cmp_ie;
    logic [CNT_W-1:0] rem;

    dmac_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .cfg_en(cfg_en), .stat_ptr(stat_ptr), .go(go),
        .dptr_we(dptr_we), .dptr_wdata(dptr_wdata),
        .irq_flag(irq_flag), .irq_out(done_irq),
        .dptr(dptr), .halted(halted), .dvalid(dvalid), .dbell(dbell),
        .rem(rem), .cmp(cmp), .cmp_ie(cmp_ie)
    );

    dmac_engine #(.CNT_W(CNT_W), .DESC_WORDS(DESC_WORDS)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .go(go), .dptr_we(dptr_we), .dptr_wdata(dptr_wdata),
        .stat_ptr(stat_ptr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .dptr(dptr), .halted(halted), .dvalid(dvalid), .dbell(dbell),
        .rem(rem), .cmp(cmp), .cmp_ie(cmp_ie)
    );
endmodule

// File: rtl/dmac_checker.sv
// Protocol and interrupt properties of the DMA channel, bound to the top.
// Assumes it sees the top's internal enable, halted, completion and irq nets.
module dmac_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [2:0]  reg_addr,
    input logic        cfg_en,
    input logic        halted,
    input logic        cmp,
    input logic        irq_flag,
    input logic        done_irq,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic        mem_req_write,
    input logic [31:0] mem_req_addr,
    input logic        mem_rsp_valid
);
    logic rd_pend_q;

    // tracks a read accepted but not yet answered
    always_ff @(posedge clk) begin
        if (!rst_n)                                          rd_pend_q <= 1'b0;
        else if (mem_req_valid && mem_req_ready && !mem_req_write) rd_pend_q <= 1'b1;
        else if (mem_rsp_valid)                              rd_pend_q <= 1'b0;
    end

    a_r10_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

    a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !rd_pend_q);

    a_r8_cmp_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
        cmp |=> irq_flag);

    a_r8_out_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> irq_flag);

    a_r2_disabled_doorbell: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd3 && !cfg_en && halted) |=> halted);
endmodule

bind dma_chain_channel dmac_checker u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .cfg_en(cfg_en), .halted(halted), .cmp(cmp), .irq_flag(irq_flag),
    .done_irq(done_irq), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/tb_dma_chain_channel.sv
module tb_dma_chain_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req_valid, mem_req_write;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_req_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic        done_irq;

    int checks = 0;
    int errors = 0;
    int hs_count = 0;
    int overlap_bad = 0;
    int hold_bad = 0;
    bit rand_ready = 1'b1;

    logic [31:0] mem [0:255];
    logic [31:0] exp_mem [0:255];

    logic        pend = 1'b0;
    int          lat = 0;
    logic [7:0]  paddr = '0;
    logic        prev_stall = 1'b0;
    logic [31:0] prev_addr = '0;

    always #2 clk = ~clk;

    dma_chain_channel dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .done_irq(done_irq)
    );

    // memory model: random ready, 1..3 cycle read latency, R10 monitoring
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (prev_stall && (!mem_req_valid || mem_req_addr != prev_addr)) hold_bad++;
        prev_stall = mem_req_valid && !mem_req_ready;
        prev_addr  = mem_req_addr;
        if (pend) begin
            if (lat == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= mem[paddr];
                pend <= 1'b0;
            end else lat <= lat - 1;
        end
        if (mem_req_valid && mem_req_ready) begin
            hs_count++;
            if (pend) overlap_bad++;
            if (mem_req_write) mem[mem_req_addr[9:2]] = mem_req_wdata;
            else begin
                pend  <= 1'b1;
                lat   <= int'($urandom % 3);
                paddr <= mem_req_addr[9:2];
            end
        end
        mem_req_ready <= rand_ready ? (($urandom % 4) != 0) : 1'b1;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_halt();
        logic [31:0] v;
        for (int n = 0; n < 6000; n++) begin
            reg_rd(3'd5, v);
            if (v[0]) return;
        end
        check("R3 halt timeout", 32'd0, 32'd1);
    endtask

    // reference walk of the chain over exp_mem
    task automatic model_chain(input logic [31:0] start, input logic [31:0] sptr,
                               output logic [31:0] end_ptr, inout logic [31:0] rem_o,
                               output bit comp, output bit ie);
        logic [31:0] a, c0, s, d, val;
        logic [21:0] bc;
        a = start; comp = 0; ie = 0;
        for (int n = 0; n < 16; n++) begin
            c0 = exp_mem[a[9:2]];
            if (!c0[31]) break;
            bc = exp_mem[a[9:2] + 1][21:0];
            s  = exp_mem[a[9:2] + 2];
            d  = exp_mem[a[9:2] + 4];
            for (int w = 0; w < int'(bc >> 2); w++) begin
                exp_mem[d[9:2]] = exp_mem[s[9:2]];
                s = s + 4;
                if (c0[30]) d = d + 4;
            end
            rem_o = {30'd0, bc[1:0]};
            if (c0[1:0] != 2'd0) begin
                case (c0[1:0])
                    2'd1:    val = 32'h6;
                    2'd2:    val = c0 & 32'h7fff_ffff;
                    default: val = rem_o;
                endcase
                if (c0[4]) exp_mem[sptr[9:2]] = val;
                else       exp_mem[a[9:2] + 6] = val;
            end
            if (c0[2]) exp_mem[a[9:2]] = c0 & 32'h7fff_ffff;
            comp = 1;
            ie = ie | c0[8];
            a = {exp_mem[a[9:2] + 7][26:0], 5'd0};
        end
        end_ptr = a;
    endtask

    task automatic cmp_mem(input string tag);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < 256; i++)
            if (mem[i] !== exp_mem[i]) begin bad++; if (first < 0) first = i; end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s: word %0d actual %h expected %h", tag, first,
                     mem[first], exp_mem[first]);
        end
    endtask

    function automatic logic [31:0] mk_cmd(bit mem_m, bit ie, bit sp, bit cv, logic [1:0] st);
        return 32'h8000_0000 | (32'(mem_m) << 30) | (32'(ie) << 8) | (32'(sp) << 4)
             | (32'(cv) << 2) | 32'(st);
    endfunction

    // build one random chain: 0x00 -> 0x40 -> 0x20 -> 0x60 (invalid)
    task automatic build_chain();
        logic [31:0] order [4];
        order[0] = 32'h00; order[1] = 32'h40; order[2] = 32'h20; order[3] = 32'h60;
        for (int i = 0; i < 256; i++) mem[i] = $urandom;
        for (int k = 0; k < 3; k++) begin
            logic [31:0] base = order[k];
            logic [31:0] words = $urandom % 9;
            mem[base[9:2]]     = mk_cmd(1'($urandom), 1'($urandom), 1'($urandom),
                                        1'($urandom), 2'($urandom));
            mem[base[9:2] + 1] = ($urandom & 32'hffc0_0000) | (words << 2) | ($urandom % 4);
            mem[base[9:2] + 2] = 32'h100 + base * 2;
            mem[base[9:2] + 4] = 32'h200 + base * 2;
            mem[base[9:2] + 7] = {5'($urandom), 27'(order[k+1] >> 5)};
        end
        mem[8'h18] = $urandom & 32'h7fff_ffff;
        for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
    endtask

    initial begin
        logic [31:0] v, endp, rem_exp;
        bit comp, ie;
        int hs0;
        void'($urandom(32'd20240611));
        rem_exp = 0;
        for (int i = 0; i < 256; i++) mem[i] = 32'd0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_rd(3'd5, v); check("R1 status", v, 32'h1);
        reg_rd(3'd4, v); check("R1 irq", v, 32'h0);
        reg_rd(3'd6, v); check("R1 bytecount", v, 32'h0);
        reg_rd(3'd1, v); check("R1 dptr", v, 32'h0);
        check("R1 done_irq", {31'd0, done_irq}, 32'h0);
        check("R1 no request", {31'd0, mem_req_valid}, 32'h0);

        // R2 doorbell ignored while disabled
        mem[0] = mk_cmd(1, 1, 0, 0, 2'd1);
        hs0 = hs_count;
        reg_wr(3'd0, 32'h0);
        reg_wr(3'd3, 32'hdead_beef);
        repeat (30) @(negedge clk);
        reg_rd(3'd5, v); check("R2 disabled status", v, 32'h1);
        check("R2 disabled no traffic", 32'(hs_count - hs0), 32'h0);

        // random chains
        for (int r = 0; r < 5; r++) begin
            build_chain();
            model_chain(32'h0, 32'h80, endp, rem_exp, comp, ie);
            reg_wr(3'd1, 32'h0000_001b);
            reg_rd(3'd1, v); check("R2 dptr alignment", v, 32'h0);
            reg_wr(3'd2, 32'h0000_0083);
            reg_rd(3'd2, v); check("R2 sptr alignment", v, 32'h80);
            reg_wr(3'd0, 32'h1);
            reg_wr(3'd3, $urandom);
            reg_rd(3'd5, v); check("R9 running halted/doorbell", v & 32'h5, 32'h4);
            reg_rd(3'd6, v); check("R9 bytecount while running", v, 32'h0);
            reg_wr(3'd1, 32'h0000_0300);
            wait_halt();
            cmp_mem("R4/R5/R6 memory image");
            reg_rd(3'd1, v); check("R7/R3 final pointer", v, endp);
            reg_rd(3'd5, v); check("R9 halted status", v, 32'h1);
            reg_rd(3'd6, v); check("R9 residue", v, rem_exp);
            reg_rd(3'd4, v); check("R8 irq set", v, {31'd0, comp});
            check("R8 done_irq", {31'd0, done_irq}, {31'd0, ie});
            reg_wr(3'd4, 32'h1);
            reg_rd(3'd4, v); check("R8 irq cleared", v, 32'h0);
            check("R8 done_irq cleared", {31'd0, done_irq}, 32'h0);
        end

        // R3 refetch of the invalid descriptor: exactly one read
        hs0 = hs_count;
        reg_wr(3'd3, 32'h1);
        wait_halt();
        check("R3 single fetch on invalid", 32'(hs_count - hs0), 32'h1);
        reg_rd(3'd1, v); check("R3 pointer kept", v, 32'h60);

        // R6 self-loop descriptor clears its own valid, then halts on itself
        mem[8'h18] = mk_cmd(0, 1, 0, 1, 2'd0);
        mem[8'h19] = 32'h0;
        mem[8'h1f] = 32'hf800_0003;
        reg_wr(3'd3, 32'h1);
        wait_halt();
        check("R6 valid cleared", mem[8'h18], mk_cmd(0, 1, 0, 1, 2'd0) & 32'h7fff_ffff);
        reg_rd(3'd1, v); check("R7 self pointer", v, 32'h60);
        check("R8 done_irq with ie", {31'd0, done_irq}, 32'h1);
        reg_wr(3'd4, 32'h1);

        // R8 clear in the completion cycle: completion wins
        rand_ready = 1'b0;
        mem[8'h18] = mk_cmd(0, 0, 0, 1, 2'd0);
        reg_wr(3'd3, 32'h1);
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            if (mem_req_valid && mem_req_ready && mem_req_write && mem_req_addr == 32'h60)
                break;
        end
        reg_wr(3'd4, 32'h1);
        wait_halt();
        reg_rd(3'd4, v); check("R8 completion beats clear", v, 32'h1);
        check("R8 done_irq without ie", {31'd0, done_irq}, 32'h0);
        reg_wr(3'd4, 32'h1);
        reg_rd(3'd4, v); check("R8 later clear", v, 32'h0);

        check("R10 one outstanding", 32'(overlap_bad), 32'h0);
        check("R10 request held", 32'(hold_bad), 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule